// File: doc/BRIEF.md
# Multi-Channel Compare-Match Timer Register Wrapper

This block places up to eight compare-match timer channels behind one word-addressed register bus. A shared run register holds one enable bit per hardware channel index. Each populated channel has a block of three registers: control/status, counter and compare value. A running channel counts up by one per clock. When the counter equals the compare value, the counter wraps to zero and the channel raises a match flag. If the channel's interrupt enable is set, the flag drives that channel's pending line. All pending lines are ORed into one interrupt output.

A build-time mask marks which hardware indices exist. Addresses of absent channels read as zero and ignore writes. The run-register bit for a channel follows its real hardware index, so a sparse mask leaves gaps in both the run register and the address map. Software sets or clears one channel's run bit by reading the run register, changing the bit and writing the value back. The other bits come back unchanged.

The read path is a two-state machine. BUS_IDLE moves to BUS_RESP on a read request. BUS_RESP stays in BUS_RESP on another read request and returns to BUS_IDLE otherwise. Read data is valid while the machine is in BUS_RESP.

Top module: `tmr_wrap`

## Requirements
- R1: After reset the run register reads 0, every populated channel's counter reads 0, its compare register reads 0xFFFFFFFF and its control register reads 0, and `irq` and `irq_pending` are 0.
- R2: Word address 0 is the run register. Bit n enables hardware channel n. Only bits set in `CH_MASK` can be written to 1; every other bit always reads 0.
- R3: Channel n's block starts at word address 4+4n, which is byte 0x10+0x10·n. Inside the block, word 0 is control, word 1 is the counter and word 2 is the compare value. The compare register holds the value written to it.
- R4: While its run bit is 1, a channel's counter increases by one on each clock. While its run bit is 0, the counter holds its value.
- R5: If a channel is running and its counter equals its compare value at a clock edge, the counter is 0 after that edge and the match flag (control bit 15) is 1.
- R6: Control bit 7 is the interrupt enable and stores the written value. Writing control bit 15 as 0 clears the match flag; writing it as 1 leaves the flag unchanged. A match in the same cycle as the write sets the flag anyway. All other control bits read 0.
- R7: A counter write loads the written value. It overrides the increment and the wrap in that cycle.
- R8: The following addresses read 0 and ignore writes: blocks of unpopulated channels, word 3 of any block, global words 1 to 3, and blocks above channel 7.
- R9: `irq_pending[n]` is 1 exactly when channel n's match flag and interrupt enable are both 1. `irq` is the OR of `irq_pending`.
- R10: A read request gives `bus_rvalid` = 1 in the next cycle, with the register value as it was in the request cycle. A cycle with no read request gives `bus_rvalid` = 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| irq | output | 1 | OR of all pending lines |
| irq_pending | output | 8 | Per-channel pending: match flag AND interrupt enable |

## Verification
The assertions assume that the bus inputs hold steady around each clock edge. They also assume that a counter write is the only way to move a counter other than by counting. The stimulus therefore drives every bus field one time unit after a rising edge, holds each request for exactly one cycle, and changes nothing else in the channel state. The run-bit patterns include both running and stopped channels, so the counting and holding properties are exercised. The compare values are small enough that the wrap property is exercised within a short run.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int DATA_W   = 32;
    localparam int FLAG_BIT = 15;
    localparam int IE_BIT   = 7;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_COUNT = 2'd1,
        REG_CMP   = 2'd2,
        REG_NONE  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CNT_W = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wr_en,
    input  reg_sel_e          wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  reg_sel_e          rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              pending
);
    logic [CNT_W-1:0] cnt_q, cmp_q;
    logic             flag_q, ie_q;
    logic             cnt_we, ctrl_we, match;

    assign cnt_we  = wr_en && (wr_sel == REG_COUNT);
    assign ctrl_we = wr_en && (wr_sel == REG_CTRL);
    assign match   = run && (cnt_q == cmp_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            cmp_q  <= '1;
            flag_q <= 1'b0;
            ie_q   <= 1'b0;
        end else begin
            if (cnt_we)
                cnt_q <= wr_data[CNT_W-1:0];
            else if (match)
                cnt_q <= '0;
            else if (run)
                cnt_q <= cnt_q + CNT_W'(1);
            if (wr_en && (wr_sel == REG_CMP))
                cmp_q <= wr_data[CNT_W-1:0];
            if (ctrl_we)
                ie_q <= wr_data[IE_BIT];
            flag_q <= match | (flag_q & ~(ctrl_we & ~wr_data[FLAG_BIT]));
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_sel)
            REG_CTRL: begin
                rd_data[FLAG_BIT] = flag_q;
                rd_data[IE_BIT]   = ie_q;
            end
            REG_COUNT: rd_data = DATA_W'(cnt_q);
            REG_CMP:   rd_data = DATA_W'(cmp_q);
            REG_NONE:  rd_data = '0;
        endcase
    end

    assign pending = flag_q & ie_q;

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_we && cnt_q == cmp_q) |=> (cnt_q == '0)); // R5
    AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt_q == cmp_q) |=> flag_q); // R5
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_we) |=> $stable(cnt_q)); // R4
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_we && cnt_q != cmp_q) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R4
endmodule

// File: rtl/tmr_rd_port.sv
module tmr_rd_port
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    bus_state_e       state_q, state_d;
    logic [DATA_W-1:0] data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (rd_req) state_d = BUS_RESP;
            BUS_RESP: if (!rd_req) state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rd_req)
                data_q <= rd_word;
        end
    end

    always_comb begin
        rvalid = (state_q == BUS_RESP);
        rdata  = rvalid ? data_q : '0;
    end

    AST_RVALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rvalid); // R10
    AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rvalid); // R10
endmodule

// File: rtl/tmr_wrap.sv
module tmr_wrap
    import tmr_pkg::*;
#(
    parameter int                NUM_CH  = 8,
    parameter logic [NUM_CH-1:0] CH_MASK = 'h65,
    parameter int                ADDR_W  = 6,
    parameter int                CNT_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              irq,
    output logic [NUM_CH-1:0] irq_pending
);
    localparam int BLK_W = ADDR_W - 2;

    logic [BLK_W-1:0]  blk;
    reg_sel_e          sel;
    logic              wr_req, rd_req, glob_hit;
    logic [NUM_CH-1:0] start_q, ch_hit;
    logic [DATA_W-1:0] ch_rd [NUM_CH];
    logic [DATA_W-1:0] rd_word;

    assign blk      = bus_addr[ADDR_W-1:2];
    assign sel      = reg_sel_e'(bus_addr[1:0]);
    assign wr_req   = bus_valid && bus_write;
    assign rd_req   = bus_valid && !bus_write;
    assign glob_hit = (blk == '0) && (sel == REG_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            start_q <= '0;
        else if (wr_req && glob_hit)
            start_q <= bus_wdata[NUM_CH-1:0] & CH_MASK;
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        assign ch_hit[n] = (blk == BLK_W'(n + 1));
        if (CH_MASK[n]) begin : g_pop
            tmr_chan #(.CNT_W(CNT_W)) u_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .run     (start_q[n]),
                .wr_en   (wr_req && ch_hit[n]),
                .wr_sel  (sel),
                .wr_data (bus_wdata),
                .rd_sel  (sel),
                .rd_data (ch_rd[n]),
                .pending (irq_pending[n])
            );
        end else begin : g_absent
            assign ch_rd[n]       = '0;
            assign irq_pending[n] = 1'b0;
        end
    end

    always_comb begin
        rd_word = '0;
        if (glob_hit)
            rd_word = DATA_W'(start_q);
        for (int n = 0; n < NUM_CH; n++)
            if (ch_hit[n])
                rd_word = ch_rd[n];
    end

    assign irq = |irq_pending;

    tmr_rd_port u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_req  (rd_req),
        .rd_word (rd_word),
        .rdata   (bus_rdata),
        .rvalid  (bus_rvalid)
    );

    AST_WRITE_NO_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write) |=> !bus_rvalid); // R10
    AST_ABSENT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_pending & ~CH_MASK) == '0)); // R8
endmodule

// File: tb/tb_tmr_wrap.sv
module tb_tmr_wrap;
    localparam int       CLK_PERIOD = 10;
    localparam logic [7:0] MASK     = 8'h65;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid, irq;
    logic [7:0]  irq_pending;

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    string cur_tag = "R10";

    tmr_wrap #(.NUM_CH(8), .CH_MASK(MASK), .ADDR_W(6), .CNT_W(32)) dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .irq(irq), .irq_pending(irq_pending));

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    int unsigned m_cnt [8];
    int unsigned m_cmp [8];
    bit          m_flag[8], m_ie[8];
    bit [7:0]    m_start;
    bit          exp_rv;
    logic [31:0] exp_rd;
    string       exp_tag;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin
                m_cnt[i] = 0; m_cmp[i] = 32'hFFFF_FFFF; m_flag[i] = 0; m_ie[i] = 0;
            end
            m_start = 0; exp_rv = 0; exp_rd = 0; exp_tag = "R1";
        end else begin
            int blk, rg, ch;
            bit [7:0] old_start;
            blk = int'(bus_addr[5:2]); rg = int'(bus_addr[1:0]); ch = blk - 1;
            exp_rv = bus_valid && !bus_write;
            if (exp_rv) begin
                exp_tag = cur_tag;
                exp_rd = 0;
                if (blk == 0 && rg == 0) exp_rd = {24'b0, m_start};
                else if (blk >= 1 && blk <= 8 && MASK[ch]) begin
                    if (rg == 0) exp_rd = (32'(m_flag[ch]) << 15) | (32'(m_ie[ch]) << 7);
                    else if (rg == 1) exp_rd = m_cnt[ch];
                    else if (rg == 2) exp_rd = m_cmp[ch];
                end
            end
            old_start = m_start;
            for (int i = 0; i < 8; i++) begin
                if (MASK[i]) begin
                    bit hit, mt;
                    hit = bus_valid && bus_write && (blk == i + 1);
                    mt  = old_start[i] && (m_cnt[i] == m_cmp[i]);
                    if (hit && rg == 0) begin
                        m_ie[i] = bus_wdata[7];
                        if (!bus_wdata[15]) m_flag[i] = 0;
                    end
                    if (mt) m_flag[i] = 1;
                    if (hit && rg == 1) m_cnt[i] = bus_wdata;
                    else if (mt) m_cnt[i] = 0;
                    else if (old_start[i]) m_cnt[i] = m_cnt[i] + 1;
                    if (hit && rg == 2) m_cmp[i] = bus_wdata;
                end
            end
            if (bus_valid && bus_write && blk == 0 && rg == 0)
                m_start = bus_wdata[7:0] & MASK;
        end
    end

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [7:0] pend;
            for (int i = 0; i < 8; i++) pend[i] = m_flag[i] & m_ie[i];
            check("R10 rvalid", 32'(bus_rvalid), 32'(exp_rv));
            check("R9 pending", 32'(irq_pending), 32'(pend));
            check("R9 irq", 32'(irq), 32'(|pend));
            if (exp_rv) check(exp_tag, bus_rdata, exp_rd);
        end
    end

    // bus tasks: called one time unit after a rising edge
    task automatic wr(logic [5:0] a, logic [31:0] d);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd(logic [5:0] a, string tag);
        cur_tag = tag;
        bus_valid = 1; bus_write = 0; bus_addr = a;
        @(posedge clk); #1;
        bus_valid = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [5:0] ca(int ch, int r);
        return 6'(4 + 4 * ch + r);
    endfunction

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        idle(1);
        // R1 reset state
        rd(6'd0, "R1 run reg");
        rd(ca(0, 0), "R1 ctrl");
        rd(ca(0, 1), "R1 count");
        rd(ca(0, 2), "R1 compare");
        rd(ca(6, 2), "R1 compare ch6");
        // R3 register placement
        wr(ca(0, 2), 32'd5);
        wr(ca(2, 2), 32'd40);
        rd(ca(0, 2), "R3 compare ch0");
        rd(ca(2, 2), "R3 compare ch2");
        wr(ca(0, 0), 32'h80);
        wr(ca(2, 0), 32'h0);
        // R2 run register masking
        wr(6'd0, 32'hFF);
        rd(6'd0, "R2 masked run bits");
        // R4 counting
        rd(ca(5, 1), "R4 count ch5");
        rd(ca(5, 1), "R4 count ch5 next");
        idle(12);
        // R5 wrap and flag
        rd(ca(0, 0), "R5 match flag");
        rd(ca(0, 1), "R5 count after wrap");
        // R6 flag clear / keep
        wr(ca(0, 0), 32'h8080);
        rd(ca(0, 0), "R6 write one keeps flag");
        wr(ca(0, 2), 32'd200);
        wr(ca(0, 1), 32'd0);
        wr(ca(0, 0), 32'h0080);
        rd(ca(0, 0), "R6 write zero clears flag");
        wr(ca(0, 0), 32'hFFFF_7F7F);
        rd(ca(0, 0), "R6 other bits read zero");
        // R7 counter load
        wr(ca(2, 1), 32'd100);
        rd(ca(2, 1), "R7 count load");
        wr(ca(6, 2), 32'd20);
        wr(ca(6, 1), 32'd20);
        rd(ca(6, 1), "R7 load beats wrap");
        // R8 unmapped space
        wr(ca(1, 2), 32'd77);
        rd(ca(1, 2), "R8 absent ch1");
        wr(ca(3, 1), 32'd9);
        rd(ca(3, 1), "R8 absent ch3");
        rd(ca(0, 3), "R8 word 3");
        wr(6'd1, 32'hFFFF);
        rd(6'd1, "R8 global word 1");
        rd(6'h3F, "R8 beyond ch7");
        // R4 halt: keep only channel 0 running
        wr(6'd0, 32'h01);
        rd(ca(5, 1), "R4 halted ch5");
        idle(3);
        rd(ca(5, 1), "R4 halted ch5 holds");
        // R9 interrupt from ch6 with enable, ch0 disabled
        wr(ca(0, 0), 32'h0);
        wr(ca(6, 2), 32'd3);
        wr(ca(6, 1), 32'd0);
        wr(ca(6, 0), 32'h80);
        wr(6'd0, 32'h40);
        idle(8);
        rd(ca(6, 0), "R9 ch6 flag");
        // R10 back-to-back reads
        rd(ca(6, 1), "R10 b2b 1");
        rd(ca(6, 1), "R10 b2b 2");
        rd(6'd0, "R10 b2b 3");
        idle(4);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule